// File: doc/BRIEF.md
# Push-Button Volume Step Controller

This block turns two active-low push buttons into a 5-bit gain-step index. It runs from a fast free-running oscillator clock. It divides that clock into a slow step tick and samples the buttons on each tick. A short press moves the index by one step. A held button repeats the step: after the first step there is a long pause, and then the steps come at a steady, faster rate.

An active-low shutdown input returns the index to a default mid-range step, as does power-on reset. The block drives two outputs: the current index, and a one-clock pulse each time a button moves the index. A downstream gain stage maps the index to an attenuation value. The index runs from 0 (minimum gain) to 31 (maximum gain). The up button raises the index and the down button lowers it.

Top module: `vol_stepper`

## Requirements
- R1: After reset, and in the clock after a synchronized low on `sd_ni`, `index_o` equals the default step (16). This return to default raises no `chg_o` pulse.
- R2: The step tick fires once every 2^PRESC_W clocks. Every interval between steps during a hold is a whole number of ticks.
- R3: While both `up_ni` and `dn_ni` are high (1), `index_o` does not change and `chg_o` stays 0.
- R4: While both buttons are low together, `index_o` does not change. This state also clears the hold sequencer, so a single button that remains low afterwards is treated as a fresh press.
- R5: A fresh press moves the index one step on the first tick that samples the button low. This happens at most 2^PRESC_W + 3 clocks after the pin falls: up adds 1 and down subtracts 1.
- R6: If the same button is still low, the second step comes exactly 10 ticks after the first.
- R7: Each further step while the button stays low comes exactly 4 ticks after the previous step.
- R8: On up, the index saturates at 31 and does not wrap. No `chg_o` pulse is raised while it is held at 31.
- R9: On down, the index saturates at 0 and does not wrap. No `chg_o` pulse is raised while it is held at 0.
- R10: A release seen on a tick restarts the sequence, so the next press steps again on its first low tick.
- R11: `chg_o` is high for exactly one clock with each change of `index_o`, and each such change is exactly ±1.
- R12: While `sd_ni` is low, the buttons have no effect: `index_o` stays at the default and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_ni | input | 1 | Up button, active low, asynchronous |
| dn_ni | input | 1 | Down button, active low, asynchronous |
| sd_ni | input | 1 | Shutdown, active low, asynchronous |
| index_o | output | IDX_W | Current gain-step index |
| chg_o | output | 1 | One-clock pulse on each index step |

## Verification
A wrong phase or count in the hold sequencer shows up at the ports as a wrong spacing of `chg_o` pulses. The fault is visible one pulse later: by the second step for the long pause, or by the third step for the repeat rate. The bench therefore measures the exact clock distance between consecutive pulses. A saturation or wrap fault shows up as an index jump or an extra pulse on the first tick after a limit is reached. A prescaler fault breaks the whole-tick spacing at once. A fault in the shutdown or sequencer-clear path shows up as a late first step after a release, or after a both-low interval.

// File: rtl/vol_pkg.sv
package vol_pkg;
  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DN   = 2'd2
  } dir_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2,
    PH_REPEAT = 2'd3
  } phase_e;
endpackage

// File: rtl/vol_sync.sv
module vol_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[i];
        sync_q <= RST_VAL[i];
      end else begin
        meta_q <= d_i[i];
        sync_q <= meta_q;
      end
    end
    assign q_o[i] = sync_q;
  end
endmodule

// File: rtl/vol_prescaler.sv
module vol_prescaler #(
  parameter int PRESC_W = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  logic [PRESC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // one clock in every 2^PRESC_W
  assign tick_o = &cnt_q;
endmodule

// File: rtl/vol_hold_seq.sv
module vol_hold_seq
  import vol_pkg::*;
#(
  parameter int FIRST_TICKS  = 1,
  parameter int SECOND_TICKS = 10,
  parameter int REPEAT_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic up_req_i,
  input  logic dn_req_i,
  output logic step_o,
  output dir_e dir_o
);
  localparam int MAX_A = (FIRST_TICKS > SECOND_TICKS) ? FIRST_TICKS : SECOND_TICKS;
  localparam int MAX_T = (MAX_A > REPEAT_TICKS) ? MAX_A : REPEAT_TICKS;
  localparam int CNT_W = $clog2(MAX_T + 1);

  phase_e            phase_q, phase_d;
  dir_e              dir_q, dir_now;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_nx, target;
  logic              fresh, fire;

  always_comb begin
    unique case ({up_req_i, dn_req_i})
      2'b10:   dir_now = DIR_UP;
      2'b01:   dir_now = DIR_DN;
      default: dir_now = DIR_NONE;
    endcase
  end

  assign fresh  = (phase_q == PH_IDLE) || (dir_now != dir_q);
  assign cnt_nx = fresh ? CNT_W'(1) : cnt_q + 1'b1;

  always_comb begin
    if (fresh) target = CNT_W'(FIRST_TICKS);
    else begin
      unique case (phase_q)
        PH_SECOND: target = CNT_W'(SECOND_TICKS);
        PH_REPEAT: target = CNT_W'(REPEAT_TICKS);
        default:   target = CNT_W'(FIRST_TICKS);
      endcase
    end
  end

  assign fire = tick_i && (dir_now != DIR_NONE) && (cnt_nx >= target);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (tick_i) begin
      if (dir_now == DIR_NONE) begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end else if (fire) begin
        cnt_d = '0;
        if (fresh || phase_q == PH_FIRST) phase_d = PH_SECOND;
        else                              phase_d = PH_REPEAT;
      end else begin
        cnt_d = cnt_nx;
        if (fresh) phase_d = PH_FIRST;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      dir_q   <= DIR_NONE;
      cnt_q   <= '0;
    end else if (clr_i) begin
      phase_q <= PH_IDLE;
      dir_q   <= DIR_NONE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (tick_i) dir_q <= dir_now;
    end
  end

  assign step_o = fire;
  assign dir_o  = dir_now;
endmodule

// File: rtl/vol_index.sv
module vol_index
  import vol_pkg::*;
#(
  parameter int IDX_W       = 5,
  parameter int DEFAULT_IDX = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  dir_e             dir_i,
  output logic [IDX_W-1:0] index_o,
  output logic             chg_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};
  localparam logic [IDX_W-1:0] IDX_DEF = IDX_W'(DEFAULT_IDX);

  logic [IDX_W-1:0] idx_q;
  logic             chg_q;
  logic             go_up, go_dn;

  assign go_up = step_i && (dir_i == DIR_UP) && (idx_q != IDX_MAX);
  assign go_dn = step_i && (dir_i == DIR_DN) && (idx_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= IDX_DEF;
      chg_q <= 1'b0;
    end else if (clr_i) begin
      idx_q <= IDX_DEF;
      chg_q <= 1'b0;
    end else begin
      chg_q <= go_up || go_dn;
      if (go_up)      idx_q <= idx_q + 1'b1;
      else if (go_dn) idx_q <= idx_q - 1'b1;
    end
  end

  assign index_o = idx_q;
  assign chg_o   = chg_q;
endmodule

// File: rtl/vol_stepper.sv
module vol_stepper
  import vol_pkg::*;
#(
  parameter int IDX_W        = 5,
  parameter int DEFAULT_IDX  = 16,
  parameter int PRESC_W      = 13,
  parameter int FIRST_TICKS  = 1,
  parameter int SECOND_TICKS = 10,
  parameter int REPEAT_TICKS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_ni,
  input  logic             dn_ni,
  input  logic             sd_ni,
  output logic [IDX_W-1:0] index_o,
  output logic             chg_o
);
  // {sd, dn, up}: buttons idle high, shutdown held until synchronized
  localparam logic [2:0] SYNC_RST = 3'b011;

  logic [2:0] sync_q;
  logic       up_s, dn_s, sd_s, shut, tick, step;
  dir_e       step_dir;

  vol_sync #(.W(3), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sd_ni, dn_ni, up_ni}),
    .q_o    (sync_q)
  );

  assign up_s = sync_q[0];
  assign dn_s = sync_q[1];
  assign sd_s = sync_q[2];
  assign shut = !sd_s;

  vol_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (shut),
    .tick_o (tick)
  );

  vol_hold_seq #(
    .FIRST_TICKS  (FIRST_TICKS),
    .SECOND_TICKS (SECOND_TICKS),
    .REPEAT_TICKS (REPEAT_TICKS)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (shut),
    .tick_i   (tick),
    .up_req_i (!up_s),
    .dn_req_i (!dn_s),
    .step_o   (step),
    .dir_o    (step_dir)
  );

  vol_index #(.IDX_W(IDX_W), .DEFAULT_IDX(DEFAULT_IDX)) u_idx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (shut),
    .step_i  (step),
    .dir_i   (step_dir),
    .index_o (index_o),
    .chg_o   (chg_o)
  );
endmodule

// File: rtl/vol_stepper_chk.sv
module vol_stepper_chk #(
  parameter int IDX_W       = 5,
  parameter int DEFAULT_IDX = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             up_s,
  input logic             dn_s,
  input logic             sd_s,
  input logic             tick,
  input logic [IDX_W-1:0] index_o,
  input logic             chg_o
);
  // R1
  shutdown_default_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sd_s |=> (index_o == IDX_W'(DEFAULT_IDX)) && !chg_o);

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(up_s && dn_s) |-> !chg_o);

  // R4
  both_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!up_s && !dn_s) |-> !chg_o);

  // R11
  unit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> (({1'b0, index_o} == {1'b0, $past(index_o)} + 1'b1) ||
               ({1'b0, index_o} + 1'b1 == {1'b0, $past(index_o)})));

  // R11
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |=> !chg_o);

  // R2
  tick_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> $past(tick));

  // R2
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick);
endmodule

bind vol_stepper vol_stepper_chk #(.IDX_W(IDX_W), .DEFAULT_IDX(DEFAULT_IDX)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .up_s    (up_s),
  .dn_s    (dn_s),
  .sd_s    (sd_s),
  .tick    (tick),
  .index_o (index_o),
  .chg_o   (chg_o)
);

// File: tb/vol_stepper_test.sv
`timescale 1ns/1ps
module vol_stepper_test;
  localparam int PW   = 4;
  localparam int TICK = 1 << PW;
  localparam int LAT  = TICK + 3;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       up_ni = 1'b1, dn_ni = 1'b1, sd_ni = 1'b1;
  logic [4:0] index_o;
  logic       chg_o;

  int checks = 0, errors = 0;
  int cyc = 0, pcnt = 0, last_t = 0, intv = 0;
  int wide_err = 0, jump_err = 0;
  logic       prev_chg = 1'b0;
  logic [4:0] prev_idx = 5'd16;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  vol_stepper #(.PRESC_W(PW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .up_ni(up_ni), .dn_ni(dn_ni),
    .sd_ni(sd_ni), .index_o(index_o), .chg_o(chg_o)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (chg_o) begin
      pcnt   <= pcnt + 1;
      intv   <= cyc - last_t;
      last_t <= cyc;
      if (prev_chg) wide_err <= wide_err + 1;
      if (!((index_o == prev_idx + 5'd1) || (index_o + 5'd1 == prev_idx)))
        jump_err <= jump_err + 1;
    end
    prev_chg <= chg_o;
    prev_idx <= index_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step_clk(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic wait_pulse(input int budget, output bit got);
    int p0 = pcnt;
    got = 1'b0;
    for (int i = 0; i < budget; i++) begin
      step_clk(1);
      if (pcnt > p0) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic t_reset();
    step_clk(5);
    chk(index_o == 5'd16, "R1 reset index", index_o, 16);
    chk(pcnt == 0, "R1 reset pulse", pcnt, 0);
  endtask

  task automatic t_idle();
    int p0 = pcnt;
    step_clk(20 * TICK);
    chk(pcnt == p0, "R3 idle pulses", pcnt - p0, 0);
    chk(index_o == 5'd16, "R3 idle index", index_o, 16);
  endtask

  task automatic t_single();
    int c0, p0;
    bit got;
    p0 = pcnt;
    up_ni = 1'b0;
    c0 = cyc;
    wait_pulse(LAT + 2, got);
    chk(got && (last_t - c0) <= LAT, "R5 first step latency", last_t - c0, LAT);
    step_clk(4 * TICK);
    up_ni = 1'b1;
    step_clk(12 * TICK);
    chk(pcnt - p0 == 1, "R5 single press pulses", pcnt - p0, 1);
    chk(index_o == 5'd17, "R5 single press index", index_o, 17);
  endtask

  task automatic t_hold();
    bit got;
    up_ni = 1'b0;
    wait_pulse(LAT + 2, got);
    chk(got, "R5 hold first step", got, 1);
    wait_pulse(11 * TICK, got);
    chk(got && intv == 10 * TICK, "R6 second step gap", intv, 10 * TICK);
    wait_pulse(5 * TICK, got);
    chk(got && intv == 4 * TICK, "R7 third step gap", intv, 4 * TICK);
    wait_pulse(5 * TICK, got);
    chk(got && intv == 4 * TICK, "R7 fourth step gap", intv, 4 * TICK);
    chk(intv % TICK == 0, "R2 tick multiple", intv % TICK, 0);
    up_ni = 1'b1;
    step_clk(2 * TICK);
    chk(index_o == 5'd21, "R7 hold index", index_o, 21);
  endtask

  task automatic t_both_low();
    int p0, c0;
    bit got;
    up_ni = 1'b0;
    wait_pulse(LAT + 2, got);
    p0 = pcnt;
    dn_ni = 1'b0;
    step_clk(20 * TICK);
    chk(pcnt == p0, "R4 both low pulses", pcnt - p0, 0);
    chk(index_o == 5'd22, "R4 both low index", index_o, 22);
    dn_ni = 1'b1;
    c0 = cyc;
    wait_pulse(LAT + 2, got);
    chk(got && (last_t - c0) <= LAT, "R4 sequencer cleared", last_t - c0, LAT);
    up_ni = 1'b1;
    step_clk(2 * TICK);
  endtask

  task automatic t_restart();
    int c0;
    bit got;
    dn_ni = 1'b0;
    wait_pulse(LAT + 2, got);
    dn_ni = 1'b1;
    step_clk(2 * TICK);
    dn_ni = 1'b0;
    c0 = cyc;
    wait_pulse(LAT + 2, got);
    chk(got && (last_t - c0) <= LAT, "R10 restart latency", last_t - c0, LAT);
    dn_ni = 1'b1;
    step_clk(2 * TICK);
    chk(index_o == 5'd21, "R10 restart index", index_o, 21);
  endtask

  task automatic t_sat_up();
    int p0;
    up_ni = 1'b0;
    step_clk(2000);
    chk(index_o == 5'd31, "R8 saturate up", index_o, 31);
    p0 = pcnt;
    step_clk(20 * TICK);
    chk(pcnt == p0, "R8 no pulse at max", pcnt - p0, 0);
    chk(index_o == 5'd31, "R8 no wrap", index_o, 31);
    up_ni = 1'b1;
    step_clk(2 * TICK);
  endtask

  task automatic t_sat_dn();
    int p0;
    dn_ni = 1'b0;
    step_clk(3000);
    chk(index_o == 5'd0, "R9 saturate down", index_o, 0);
    p0 = pcnt;
    step_clk(20 * TICK);
    chk(pcnt == p0, "R9 no pulse at min", pcnt - p0, 0);
    chk(index_o == 5'd0, "R9 no wrap", index_o, 0);
    dn_ni = 1'b1;
    step_clk(2 * TICK);
  endtask

  task automatic t_shutdown();
    int p0 = pcnt;
    bit got;
    sd_ni = 1'b0;
    step_clk(4);
    chk(index_o == 5'd16, "R1 shutdown default", index_o, 16);
    chk(pcnt == p0, "R1 shutdown silent", pcnt - p0, 0);
    up_ni = 1'b0;
    step_clk(20 * TICK);
    chk(index_o == 5'd16, "R12 press ignored index", index_o, 16);
    chk(pcnt == p0, "R12 press ignored pulse", pcnt - p0, 0);
    sd_ni = 1'b1;
    wait_pulse(2 * TICK, got);
    chk(got && index_o == 5'd17, "R12 resumes after shutdown", index_o, 17);
    up_ni = 1'b1;
    step_clk(2 * TICK);
  endtask

  initial begin
    step_clk(3);
    rst_ni = 1'b1;
    t_reset();
    t_idle();
    t_single();
    t_hold();
    t_both_low();
    t_restart();
    t_sat_up();
    t_sat_dn();
    t_shutdown();
    chk(wide_err == 0, "R11 pulse width", wide_err, 0);
    chk(jump_err == 0, "R11 unit step", jump_err, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule